// File: doc/BRIEF.md
# Bi-phase Bit Period Decoder

This block turns a demodulated bi-phase data line into a stream of data bits. It runs on a sample clock and counts the clock cycles between successive edges of the line. Each interval is compared against a tolerance window derived from a programmable bit period, in sample clocks. For a 2 kbit/s stream that period is the sample rate divided by 2000. A single interval close to one full bit period gives a 0 bit. Two consecutive intervals whose sum is close to a full period give a 1 bit.

An interval well beyond a bit period that yields no bit signals that the line has gone quiet. Downstream framing logic uses this to abandon any partial byte or packet. After such a gap, a half-period interval that leaves the line low still recovers a 1 bit. This handles a stream whose first half-bit merged into the idle gap. Framing, parity and packet assembly are the job of the logic that consumes the strobes.

Top module: `bpd_decoder`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, all three outputs are low.
- R2: An interval is the number of sample clocks from one line edge to the next. With P the bit period, lo = floor(3P/4) and hi = floor(5P/4). A value x is in the window only when lo < x < hi, with both comparisons strict.
- R3: At an edge, if a previous interval is held in history and the previous interval plus the current interval is in the window, a bit of value 1 is reported and the history is emptied.
- R4: At an edge where R3 and R5 do not apply and the current interval alone is in the window, a bit of value 0 is reported and the history is emptied.
- R5: At an edge where the line is low after the edge, twice the current interval is in the window, and the held previous interval exceeds hi, a bit of value 1 is reported and the history is emptied.
- R6: At an edge that yields no bit and whose interval exceeds hi, `idle_abort_o` pulses. The interval is kept as history, so R5 can apply at the next edge.
- R7: An edge yielding no bit whose interval does not exceed hi produces no strobe. Its interval replaces the history.
- R8: The interval counter saturates at its maximum, 2^CW-1, instead of wrapping. An arbitrarily long gap is therefore still treated as too long.
- R9: Each strobe lasts exactly one cycle and appears in the cycle after the edge that caused it. `bit_valid_o` and `idle_abort_o` are never high together. `bit_value_o` is low whenever `bit_valid_o` is low. No strobe appears in a cycle that does not follow an edge.
- R10: The interval counter leaves reset saturated, so the first edge after reset is classified as too long (R6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Demodulated data line, synchronous to clk |
| period_i | input | PW | Nominal bit period in sample clocks |
| bit_valid_o | output | 1 | One-cycle strobe: a bit was decoded |
| bit_value_o | output | 1 | Value of the decoded bit, qualified by bit_valid_o |
| idle_abort_o | output | 1 | One-cycle strobe: too-long interval, loss of signal |

## Verification
The embedded properties check the cycle-level invariants on every cycle:
- strobes are exclusive, last one cycle and follow only edges;
- the history is empty after a bit and still held after an abort;
- the counter never wraps;
- the window bounds stay ordered.

Whether the right bit is chosen can only be shown by scenarios. The bench sweeps every pair of intervals after a long gap, at both line polarities. This covers the pairing rule, the single-interval rule, the recovery rule and the strict window edges. It also runs a shorter sweep at a second period, a gap past counter saturation, and the first edge after reset.

// File: rtl/bpd_pkg.sv
package bpd_pkg;
  // Outcome of classifying one edge interval
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_ZERO = 2'd1,
    EV_ONE  = 2'd2,
    EV_LOST = 2'd3
  } bpd_event_e;
endpackage

// File: rtl/bpd_interval_timer.sv
module bpd_interval_timer #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_i,
  output logic          edge_o,
  output logic          level_o,
  output logic [CW-1:0] len_o
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic          line_q;
  logic [CW-1:0] cnt_q, cnt_d;

  // Edge seen when the live sample differs from the last one
  assign edge_o  = line_i ^ line_q;
  assign level_o = line_i;
  assign len_o   = cnt_q;

  always_comb begin
    if (edge_o)                cnt_d = CNT_ONE;
    else if (cnt_q == CNT_MAX) cnt_d = CNT_MAX;
    else                       cnt_d = cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      cnt_q  <= CNT_MAX;   // R10: leave reset saturated
    end else begin
      line_q <= line_i;
      cnt_q  <= cnt_d;
    end
  end

  // R8: with no edge the count never goes down (no wrap)
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_o |=> (cnt_q >= $past(cnt_q)));

  // R8: a saturated count stays saturated until an edge
  a_r8_saturate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_o && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/bpd_window.sv
module bpd_window #(
  parameter int PW = 12,
  parameter int WW = 16
) (
  input  logic [PW-1:0] period_i,
  output logic [WW-1:0] lo_o,
  output logic [WW-1:0] hi_o
);
  logic [WW-1:0] p;

  assign p = WW'(period_i);

  // R2: floor(3P/4) and floor(5P/4) from shifts and adds
  assign lo_o = (p + (p << 1)) >> 2;
  assign hi_o = (p + (p << 2)) >> 2;
endmodule

// File: rtl/bpd_classifier.sv
module bpd_classifier
  import bpd_pkg::*;
#(
  parameter int CW = 12,
  parameter int WW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          edge_i,
  input  logic          level_i,
  input  logic [CW-1:0] len_i,
  input  logic [WW-1:0] lo_i,
  input  logic [WW-1:0] hi_i,
  output logic          bit_valid_o,
  output logic          bit_value_o,
  output logic          abort_o
);
  logic          hist_v_q, hist_v_d;
  logic [CW-1:0] hist_q, hist_d;
  logic [WW-1:0] cur, prev, pair_sum, cur_dbl;
  logic          pair_ok, recover_ok, single_ok, too_long;
  bpd_event_e    ev;

  function automatic logic in_win(input logic [WW-1:0] x,
                                  input logic [WW-1:0] lo,
                                  input logic [WW-1:0] hi);
    return (x > lo) && (x < hi);
  endfunction

  assign cur      = WW'(len_i);
  assign prev     = WW'(hist_q);
  assign pair_sum = prev + cur;
  assign cur_dbl  = cur << 1;

  assign pair_ok    = hist_v_q && in_win(pair_sum, lo_i, hi_i);
  assign recover_ok = hist_v_q && !level_i && in_win(cur_dbl, lo_i, hi_i)
                      && (prev > hi_i);
  assign single_ok  = in_win(cur, lo_i, hi_i);
  assign too_long   = cur > hi_i;

  // Priority: pairing or recovery, then single interval, then too long
  always_comb begin
    ev = EV_NONE;
    if (edge_i) begin
      if (pair_ok || recover_ok) ev = EV_ONE;
      else if (single_ok)        ev = EV_ZERO;
      else if (too_long)         ev = EV_LOST;
    end
  end

  always_comb begin
    hist_v_d = hist_v_q;
    hist_d   = hist_q;
    if (edge_i) begin
      if (ev == EV_ONE || ev == EV_ZERO) begin
        hist_v_d = 1'b0;
      end else begin
        hist_v_d = 1'b1;
        hist_d   = len_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_v_q    <= 1'b0;
      hist_q      <= '0;
      bit_valid_o <= 1'b0;
      bit_value_o <= 1'b0;
      abort_o     <= 1'b0;
    end else begin
      hist_v_q    <= hist_v_d;
      hist_q      <= hist_d;
      bit_valid_o <= (ev == EV_ONE) || (ev == EV_ZERO);
      bit_value_o <= (ev == EV_ONE);
      abort_o     <= (ev == EV_LOST);
    end
  end

  // R9: bit and abort strobes never coincide
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_valid_o && abort_o));

  // R9: a value is only shown with a valid bit
  a_r9_value_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    bit_value_o |-> bit_valid_o);

  // R9: no strobe unless the previous cycle held an edge
  a_r9_only_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_i |=> !(bit_valid_o || abort_o));

  // R9: strobes last one cycle
  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid_o || abort_o) |=> !(bit_valid_o || abort_o));

  // R3: history is empty once a bit has been reported
  a_r3_history_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid_o |-> !hist_v_q);

  // R6: a too-long interval stays in history
  a_r6_history_kept: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> hist_v_q);

  // R2: window bounds are ordered
  a_r2_bounds_ordered: assert property (@(posedge clk) disable iff (!rst_n)
    lo_i <= hi_i);
endmodule

// File: rtl/bpd_decoder.sv
module bpd_decoder #(
  parameter int PW = 12,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_i,
  input  logic [PW-1:0] period_i,
  output logic          bit_valid_o,
  output logic          bit_value_o,
  output logic          idle_abort_o
);
  // Compare width: holds 5P/4 and the sum of two intervals
  localparam int WW = ((PW > CW) ? PW : CW) + 3;

  logic          edge_s, level_s;
  logic [CW-1:0] len_s;
  logic [WW-1:0] lo_s, hi_s;

  bpd_interval_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_i  (line_i),
    .edge_o  (edge_s),
    .level_o (level_s),
    .len_o   (len_s)
  );

  bpd_window #(.PW(PW), .WW(WW)) u_window (
    .period_i (period_i),
    .lo_o     (lo_s),
    .hi_o     (hi_s)
  );

  bpd_classifier #(.CW(CW), .WW(WW)) u_class (
    .clk         (clk),
    .rst_n       (rst_n),
    .edge_i      (edge_s),
    .level_i     (level_s),
    .len_i       (len_s),
    .lo_i        (lo_s),
    .hi_i        (hi_s),
    .bit_valid_o (bit_valid_o),
    .bit_value_o (bit_value_o),
    .abort_o     (idle_abort_o)
  );
endmodule

// File: tb/tb_bpd_decoder.sv
module tb_bpd_decoder;
  localparam int PW      = 12;
  localparam int CW      = 12;
  localparam int CNT_MAX = (1 << CW) - 1;
  localparam int LONG    = 24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          line;
  logic [PW-1:0] period;
  logic          bit_valid, bit_value, idle_abort;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;
  int  lo, hi;
  bit  hv;
  int  h;
  bit  first_edge;

  always #2.5 clk = ~clk;

  bpd_decoder #(.PW(PW), .CW(CW)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_i       (line),
    .period_i     (period),
    .bit_valid_o  (bit_valid),
    .bit_value_o  (bit_value),
    .idle_abort_o (idle_abort)
  );

  task automatic check(input string tag, input logic [2:0] got,
                       input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: {valid,value,abort} actual=%b expected=%b",
               tag, got, exp);
    end
  endtask

  // R2: window bounds computed from the period
  task automatic set_period(input int p);
    period = PW'(p);
    lo = (3 * p) / 4;
    hi = (5 * p) / 4;
  endtask

  function automatic bit inw(input int x);
    return (x > lo) && (x < hi);
  endfunction

  // Toggle the line n cycles after the previous toggle, then check
  task automatic step(input int n, input string ctx);
    int l;
    bit low;
    logic [2:0] exp;
    string tag;
    if (n > 1) begin
      @(negedge clk);
      check("R9 strobe cleared", {bit_valid, bit_value, idle_abort}, 3'b000);
      repeat (n - 2) @(negedge clk);
    end
    line = ~line;
    low  = (line == 1'b0);
    l = first_edge ? CNT_MAX : ((n > CNT_MAX) ? CNT_MAX : n);
    first_edge = 0;
    if (hv && inw(h + l)) begin
      exp = 3'b110; tag = "R3 pair"; hv = 0;
    end else if (hv && low && inw(2 * l) && h > hi) begin
      exp = 3'b110; tag = "R5 recovery"; hv = 0;
    end else if (inw(l)) begin
      exp = 3'b100; tag = "R4 single"; hv = 0;
    end else if (l > hi) begin
      exp = 3'b001; tag = "R6 too long"; hv = 1; h = l;
    end else begin
      exp = 3'b000; tag = "R7 short"; hv = 1; h = l;
    end
    @(negedge clk);
    check({ctx, tag}, {bit_valid, bit_value, idle_abort}, exp);
  endtask

  initial begin
    rst_n = 1'b0;
    line  = 1'b0;
    hv = 0; h = 0; first_edge = 1;
    set_period(16);
    repeat (3) @(negedge clk);
    check("R1 in reset", {bit_valid, bit_value, idle_abort}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {bit_valid, bit_value, idle_abort}, 3'b000);
    repeat (5) @(negedge clk);
    // R10: first edge sees a saturated counter
    step(7, "R10 ");

    // R2/R3/R4/R5/R6/R7: every pair of intervals after a long gap, both polarities
    for (int pol = 0; pol < 2; pol++) begin
      for (int a = 1; a <= 26; a++) begin
        for (int b = 1; b <= 26; b++) begin
          if (line == logic'(pol)) step(LONG, "");
          step(LONG, "");
          step(a, "");
          step(b, "");
        end
      end
    end

    // R8: gap longer than the counter range
    step(CNT_MAX + 900, "R8 ");
    step(8, "R8 after ");

    // R2: second period, singles and pairs around the window edges
    set_period(10);
    for (int a = 1; a <= 15; a++) begin
      for (int b = 1; b <= 15; b++) begin
        step(LONG, "");
        step(a, "");
        step(b, "");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule